// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical page address through a small set of programmable block windows. It keeps two separate banks of window descriptors, one consulted by instruction fetches and one by loads and stores. Each window is a pair of 32-bit words. The tag word holds the compare bits, a block-length mask and two mode-validity flags. The target word holds the real page bits and a two-bit protection code.

For each request, every window in the selected bank is compared at once. The lowest-numbered window that both matches the address and is enabled for the current privilege mode is chosen. The physical address is built from that window's real page bits and the address bits that the block-length mask lets through. The protection code is then checked against the access kind. The outcome is registered and presented one cycle after the request. Windows are loaded through a plain one-word-per-cycle write port. Page-table translation lies outside this block.

Top module: `block_xlate`

## Requirements
- R1: After reset all window words are zero, so every window is disabled, and all response outputs are zero.
- R2: A window matches only if address bits 31:28 equal tag-word bits 31:28 exactly.
- R3: The block-length mask is tag-word bits 12:2, applied to address bits 27:17 (tag bit 2 covers address bit 17). Address bits 27:17 with the mask bits cleared must equal tag-word bits 27:17.
- R4: A matching window is enabled for supervisor requests (reqUser=0) when tag bit 1 is set, and for user requests (reqUser=1) when tag bit 0 is set. A match on a window that is not enabled for the current mode is ignored.
- R5: When several enabled windows match, the lowest index wins.
- R6: The physical address is formed as follows. Bits 31:28 come from target bits 31:28. Bits 27:17 are target bits 27:17 OR (address bits 27:17 AND mask). Bits 16:12 come from the address. Bits 11:0 are zero.
- R7: The protection code (target bits 1:0) sets rspPerm = {read, write, execute}. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R8: On a selected window, an access the permissions allow gives rspHit=1. Otherwise rspFault=1 and rspHit=0. The rules are: a fetch needs execute, a store needs write, a load needs read. rspPhysAddr and rspPerm are reported in both cases.
- R9: Fetches (reqFetch=1) use the instruction bank only, and reqStore is then ignored. Loads and stores use the data bank only.
- R10: The outcome of a request on reqValid appears one cycle later, with rspValid high for exactly that cycle. Without reqValid the result outputs hold their last values.
- R11: A write with cfgWrEn stores cfgWrData into window cfgWrIdx. cfgWrInstr picks the bank (1 = instruction), and cfgWrUpper picks the tag word (1) or the target word (0).
- R12: When no enabled window matches, rspHit, rspFault, rspPhysAddr and rspPerm are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Window word write strobe |
| cfgWrInstr | input | 1 | Bank select for the write: 1 instruction, 0 data |
| cfgWrUpper | input | 1 | Word select for the write: 1 tag word, 0 target word |
| cfgWrIdx | input | IDX_W | Window index for the write |
| cfgWrData | input | 32 | Word value to store |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Effective address |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqStore | input | 1 | Data request is a store (ignored on fetches) |
| reqUser | input | 1 | Request made in user mode |
| rspValid | output | 1 | Result of the previous cycle's request is present |
| rspHit | output | 1 | Window selected and access allowed |
| rspFault | output | 1 | Window selected but access denied |
| rspPhysAddr | output | 32 | Translated page address |
| rspPerm | output | 3 | Granted permissions {read, write, execute} |

## Verification
Every result is due exactly one clock edge after the request: the request is driven on a falling edge, captured on the next rising edge, and compared on the falling edge after that. The bench therefore never looks at an output in the cycle it changes. A write issued on a falling edge takes effect at the next rising edge, and the bench issues no request until that edge has passed. The hold behaviour is checked on an idle cycle placed straight after a response: the inputs change, and the outputs must keep their values while rspValid is low.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  localparam int WORD_W = 32;
  localparam int PAGE_LO = 12;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic wrInstr;
    logic capture;
  } blkxCtl_t;

  typedef struct packed {
    logic              hit;
    logic              fault;
    logic [WORD_W-1:0] physAddr;
    logic [2:0]        perm;
  } blkxRes_t;

  function automatic logic [2:0] ppToPerm(input logic [1:0] pp);
    logic [2:0] p;
    case (pp)
      2'd0:    p = 3'b000;
      2'd2:    p = 3'b111;
      default: p = 3'b101;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
  import blkx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWrEn,
  input  logic     cfgWrInstr,
  input  logic     cfgWrUpper,
  input  logic     reqValid,
  output blkxCtl_t ctl,
  output logic     rspValid
);

  always_comb begin
    ctl.wrUpper = cfgWrEn & cfgWrUpper;
    ctl.wrLower = cfgWrEn & ~cfgWrUpper;
    ctl.wrInstr = cfgWrInstr;
    ctl.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R11: one word is written per cycle
  a_r11_one_word: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrUpper, ctl.wrLower}));

  // R10: a response flag follows each request by one cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/blkx_dp.sv
module blkx_dp
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  blkxCtl_t          ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqFetch,
  input  logic              reqStore,
  input  logic              reqUser,
  output blkxRes_t          res
);

  localparam int SIDES = 2;   // 0 data, 1 instruction
  localparam int BL_W  = 11;  // mask covers address bits 27:17

  logic [WORD_W-1:0] tagReg [SIDES][ENTRIES];
  logic [WORD_W-1:0] tgtReg [SIDES][ENTRIES];

  // Window word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SIDES; s++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          tagReg[s][e] <= '0;
          tgtReg[s][e] <= '0;
        end
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wrIdx == IDX_W'(e)) begin
          if (ctl.wrUpper) tagReg[ctl.wrInstr][e] <= wrData;
          if (ctl.wrLower) tgtReg[ctl.wrInstr][e] <= wrData;
        end
      end
    end
  end

  // Parallel compare over the selected bank
  logic [ENTRIES-1:0] selVec;
  logic [WORD_W-1:0]  bankTag [ENTRIES];
  logic [WORD_W-1:0]  bankTgt [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [BL_W-1:0] blMask;
    logic            addrEq;
    logic            modeOk;
    assign bankTag[g] = reqFetch ? tagReg[1][g] : tagReg[0][g];
    assign bankTgt[g] = reqFetch ? tgtReg[1][g] : tgtReg[0][g];
    assign blMask     = bankTag[g][12:2];
    assign addrEq     = (reqAddr[31:28] == bankTag[g][31:28]) &&
                        ((reqAddr[27:17] & ~blMask) == bankTag[g][27:17]);
    assign modeOk     = reqUser ? bankTag[g][0] : bankTag[g][1];
    assign selVec[g]  = addrEq & modeOk;
  end

  // Lowest index wins
  logic [IDX_W-1:0] selIdx;
  logic             found;
  always_comb begin
    selIdx = '0;
    found  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (selVec[i]) begin
        selIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  logic [WORD_W-1:0] winTag, winTgt, paComb;
  logic [2:0]        permComb;
  logic              allowed;
  blkxRes_t          resComb;

  always_comb begin
    winTag   = bankTag[selIdx];
    winTgt   = bankTgt[selIdx];
    paComb   = {winTgt[31:28],
                winTgt[27:17] | (reqAddr[27:17] & winTag[12:2]),
                reqAddr[16:12],
                {PAGE_LO{1'b0}}};
    permComb = ppToPerm(winTgt[1:0]);
    if (reqFetch)      allowed = permComb[0];
    else if (reqStore) allowed = permComb[1];
    else               allowed = permComb[2];
    resComb.hit      = found & allowed;
    resComb.fault    = found & ~allowed;
    resComb.physAddr = found ? paComb : '0;
    resComb.perm     = found ? permComb : 3'b000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            res <= '0;
    else if (ctl.capture) res <= resComb;
  end

  // R8: hit and fault are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(res.hit && res.fault));
  // R12: a miss leaves address and permissions at zero
  a_r12_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!res.hit && !res.fault) |-> (res.physAddr == '0 && res.perm == 3'b000));
  // R7: only three permission patterns exist
  a_r7_perm_shape: assert property (@(posedge clk) disable iff (!rstN)
    res.perm == 3'b000 || res.perm == 3'b101 || res.perm == 3'b111);
  // R6: page-aligned output
  a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rstN)
    res.physAddr[PAGE_LO-1:0] == '0);
  // R10: result holds while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(res));

endmodule

// File: rtl/block_xlate.sv
module block_xlate
  import blkx_pkg::*;
#(
  parameter  int ENTRIES = 4,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgWrInstr,
  input  logic             cfgWrUpper,
  input  logic [IDX_W-1:0] cfgWrIdx,
  input  logic [31:0]      cfgWrData,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic             reqFetch,
  input  logic             reqStore,
  input  logic             reqUser,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspFault,
  output logic [31:0]      rspPhysAddr,
  output logic [2:0]       rspPerm
);

  blkxCtl_t ctl;
  blkxRes_t res;

  blkx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrInstr(cfgWrInstr),
    .cfgWrUpper(cfgWrUpper), .reqValid(reqValid), .ctl(ctl), .rspValid(rspValid)
  );

  blkx_dp #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(cfgWrIdx), .wrData(cfgWrData),
    .reqAddr(reqAddr), .reqFetch(reqFetch), .reqStore(reqStore),
    .reqUser(reqUser), .res(res)
  );

  assign rspHit      = res.hit;
  assign rspFault    = res.fault;
  assign rspPhysAddr = res.physAddr;
  assign rspPerm     = res.perm;

endmodule

// File: tb/sim_block_xlate.sv
`timescale 1ns/1ps
module sim_block_xlate;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWrInstr = 1'b0, cfgWrUpper = 1'b0;
  logic [1:0]  cfgWrIdx = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0, reqFetch = 1'b0, reqStore = 1'b0, reqUser = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspHit, rspFault;
  logic [31:0] rspPhysAddr;
  logic [2:0]  rspPerm;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  block_xlate #(.ENTRIES(N)) u0 (.*);

  logic [31:0] mTag [2][N];
  logic [31:0] mTgt [2][N];

  // Expected {valid, hit, fault, pa, perm} from the requirements
  function automatic logic [37:0] expect_rsp(input logic [31:0] a,
      input bit f, input bit st, input bit u);
    int s;
    s = f ? 1 : 0;
    for (int i = 0; i < N; i++) begin
      logic [10:0] bl;
      logic [2:0]  pm;
      logic [31:0] pa;
      bit ok;
      bl = mTag[s][i][12:2];
      if (a[31:28] == mTag[s][i][31:28] && (a[27:17] & ~bl) == mTag[s][i][27:17] &&
          (u ? mTag[s][i][0] : mTag[s][i][1])) begin
        pm = (mTgt[s][i][1:0] == 2'd0) ? 3'b000 :
             (mTgt[s][i][1:0] == 2'd2) ? 3'b111 : 3'b101;
        pa = {mTgt[s][i][31:28], mTgt[s][i][27:17] | (a[27:17] & bl), a[16:12], 12'h000};
        ok = f ? pm[0] : (st ? pm[1] : pm[2]);
        return {1'b1, ok, !ok, pa, pm};
      end
    end
    return {1'b1, 1'b0, 1'b0, 32'h0, 3'b000};
  endfunction

  task automatic check(input string tag, input logic [37:0] exp);
    logic [37:0] act;
    act = {rspValid, rspHit, rspFault, rspPhysAddr, rspPerm};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit instr, input int idx, input bit upper, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrInstr = instr; cfgWrUpper = upper;
    cfgWrIdx = 2'(idx); cfgWrData = d;
    if (upper) mTag[instr ? 1 : 0][idx] = d; else mTgt[instr ? 1 : 0][idx] = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < N; e++) begin
        wr(s == 1, e, 1'b1, 32'h0);
        wr(s == 1, e, 1'b0, 32'h0);
      end
  endtask

  // Drive on a falling edge, result registered at the next rising edge,
  // compared on the falling edge after it.
  task automatic req_chk(input string tag, input logic [31:0] a, input bit f,
      input bit st, input bit u);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqFetch = f; reqStore = st; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, expect_rsp(a, f, st, u));
  endtask

  task automatic req_fix(input string tag, input logic [31:0] a, input bit f,
      input bit st, input bit u, input logic hit, input logic flt,
      input logic [31:0] pa, input logic [2:0] pm);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqFetch = f; reqStore = st; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, {1'b1, hit, flt, pa, pm});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [37:0] held;
    void'($urandom(32'h1bad5eed));
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < N; e++) begin mTag[s][e] = '0; mTgt[s][e] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", 38'h0);
    req_fix("R1 windows disabled after reset", 32'h0000_0000, 1'b0, 1'b0, 1'b0,
            1'b0, 1'b0, 32'h0, 3'b000);

    // Directed corners
    wr(0, 0, 1, 32'h1000_0003);
    wr(0, 0, 0, 32'h8002_0002);
    req_fix("R6 R11 basic hit", 32'h1000_5ABC, 0, 0, 0, 1, 0, 32'h8002_5000, 3'b111);
    req_fix("R2 R12 top nibble differs", 32'h2000_5000, 0, 0, 0, 0, 0, 32'h0, 3'b000);
    wr(0, 0, 1, 32'h1000_001F);
    req_fix("R3 masked bits relax", 32'h100A_5000, 0, 0, 0, 1, 0, 32'h800A_5000, 3'b111);
    req_fix("R3 unmasked bit differs", 32'h1010_5000, 0, 0, 0, 0, 0, 32'h0, 3'b000);
    wr(0, 0, 1, 32'h1000_0002);
    req_fix("R4 supervisor-only window, user", 32'h1000_5000, 0, 0, 1, 0, 0, 32'h0, 3'b000);
    req_fix("R4 supervisor-only window, supervisor", 32'h1000_5000, 0, 0, 0, 1, 0, 32'h8002_5000, 3'b111);
    wr(0, 1, 1, 32'h1000_0003);
    wr(0, 1, 0, 32'h4000_0001);
    req_fix("R5 R4 skipped window, user", 32'h1000_3000, 0, 0, 1, 1, 0, 32'h4000_3000, 3'b101);
    req_fix("R5 lowest index wins", 32'h1000_3000, 0, 0, 0, 1, 0, 32'h8002_3000, 3'b111);
    req_fix("R8 store to read-only", 32'h1000_3000, 0, 1, 1, 0, 1, 32'h4000_3000, 3'b101);
    req_fix("R8 store to writable", 32'h1000_3000, 0, 1, 0, 1, 0, 32'h8002_3000, 3'b111);
    wr(0, 1, 0, 32'h4000_0000);
    req_fix("R7 R8 code 0 denies load", 32'h1000_3000, 0, 0, 1, 0, 1, 32'h4000_3000, 3'b000);
    wr(0, 1, 0, 32'h4000_0003);
    req_fix("R7 code 3 read allowed", 32'h1000_3000, 0, 0, 1, 1, 0, 32'h4000_3000, 3'b101);
    req_fix("R9 fetch ignores data bank", 32'h1000_3000, 1, 0, 1, 0, 0, 32'h0, 3'b000);
    wr(1, 2, 1, 32'h1000_0001);
    wr(1, 2, 0, 32'h2000_0001);
    req_fix("R9 R8 fetch executable, store ignored", 32'h1000_3000, 1, 1, 1, 1, 0, 32'h2000_3000, 3'b101);
    req_fix("R9 R4 fetch supervisor miss", 32'h1000_3000, 1, 0, 0, 0, 0, 32'h0, 3'b000);
    wr(1, 2, 0, 32'h2000_0000);
    req_fix("R8 fetch from no-access", 32'h1000_3000, 1, 0, 1, 0, 1, 32'h2000_3000, 3'b000);

    // R10: hold while idle
    req_fix("R10 response before idle", 32'h1000_3000, 0, 0, 1, 1, 0, 32'h4000_3000, 3'b101);
    held = {1'b0, rspHit, rspFault, rspPhysAddr, rspPerm};
    reqAddr = 32'hFFFF_F000; reqUser = 1'b0; reqFetch = 1'b1;
    @(negedge clk);
    check("R10 idle holds result", held);

    // Random windows and requests against the model
    for (int round = 0; round < 6; round++) begin
      clear_all();
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < N; e++) begin
          int k;
          logic [10:0] bl;
          logic [31:0] t;
          k  = $urandom_range(0, 11);
          bl = 11'((32'h1 << k) - 1);
          t  = {4'($urandom_range(0, 3)), 11'($urandom) & ~bl, 2'b00, bl,
                2'($urandom_range(0, 3))};
          if ($urandom_range(0, 4) == 0) t[27:17] = 11'($urandom);
          wr(s == 1, e, 1'b1, t);
          wr(s == 1, e, 1'b0, $urandom);
        end
      for (int r = 0; r < 60; r++) begin
        logic [31:0] a;
        bit f, st, u;
        int e;
        f = $urandom_range(0, 1) == 1;
        st = $urandom_range(0, 1) == 1;
        u = $urandom_range(0, 1) == 1;
        e = $urandom_range(0, N - 1);
        a = $urandom;
        if ($urandom_range(0, 3) != 0) begin
          a[31:28] = mTag[f ? 1 : 0][e][31:28];
          a[27:17] = mTag[f ? 1 : 0][e][27:17] | (a[27:17] & mTag[f ? 1 : 0][e][12:2]);
        end
        req_chk("R2 R3 R4 R5 R6 R7 R8 R9 R12 random", a, f, st, u);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule